// File: doc/BRIEF.md
# Eight-Phase Machine-Cycle Sequencer

This block paces a small 8-bit processor that addresses 16-bit memory. Every machine cycle is a fixed frame of eight clock phases. The sequencer moves from frame to frame through four kinds of cycle: opcode fetch, execute, DMA and interrupt. It drives a two-bit cycle code so that external logic can tell who owns the bus. It captures the opcode byte at the end of each fetch. It splits that byte into an instruction group (upper nibble) and a register selector (lower nibble) for the datapath, which lies outside this block.

A 16-bit address from the datapath leaves on eight pins. The high byte is driven first, while an address-latch strobe is high, and the low byte is driven for the rest of the frame. Most instructions use one fetch frame and one execute frame. Instructions in the long group use two execute frames. The all-zero opcode parks the core in repeated execute frames until a DMA or interrupt request pulls it out.

Top module: `mcycle_seq`

## Requirements
- R1: The phase output counts 0,1,...,7 and wraps to 0, one step per clock. The cycle code changes only at the edge that ends phase 7.
- R2: While reset is asserted the block shows phase 0, cycle code 00 (fetch), strobe high, idle low and group/register 0.
- R3: A fetch frame is always followed by an execute frame. For an opcode outside group 0xC and not 0x00, exactly one execute frame follows, then the next fetch when no request is pending.
- R4: An opcode whose upper nibble is 0xC is followed by exactly two execute frames before the next instruction boundary.
- R5: The opcode input is captured at the end of phase 7 of a fetch frame. The group output equals bits 7:4 and the register output equals bits 3:0 of that byte, held until the next fetch ends.
- R6: Opcode 0x00 gives execute frames with idle_o high, repeated as long as neither request is high at the end of the frame.
- R7: At an instruction boundary (the last execute frame, a DMA frame, or an idle frame) the next frame is DMA if dma_req_i is high, else interrupt if irq_i is high, else fetch. DMA frames repeat while the request stays high.
- R8: An interrupt frame is followed by a DMA frame if dma_req_i is high, otherwise by a fetch, never directly by another interrupt frame.
- R9: During phases 0 and 1, addr_o carries address bits 15:8 and ale_o is high. During phases 2 to 7, addr_o carries bits 7:0 and ale_o is low.
- R10: The cycle code is 00 for fetch, 01 for execute, 10 for DMA and 11 for interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request, sampled at the end of phase 7 |
| dma_req_i | input | 1 | DMA request, sampled at the end of phase 7 |
| opcode_i | input | 8 | Opcode byte from memory, captured at the end of a fetch |
| addr_i | input | 16 | Full address supplied by the datapath |
| addr_o | output | 8 | Multiplexed address byte |
| ale_o | output | 1 | High while the high address byte is on addr_o |
| sc_o | output | 2 | Cycle code of the current frame |
| phase_o | output | 3 | Phase within the frame |
| cycle_end_o | output | 1 | High during phase 7 |
| op_group_o | output | 4 | Instruction group of the captured opcode |
| op_reg_o | output | 4 | Register selector of the captured opcode |
| idle_o | output | 1 | High during execute frames of the idle opcode |

## Verification
The assertions take for granted that the request inputs and the opcode are stable around the clock edge that closes phase 7, because only that edge samples them. The stimulus changes opcode, irq_i and dma_req_i only at the falling edge in phase 0 of a frame and holds them for the whole frame. Every sampled value is therefore unambiguous. addr_i is held constant, so that the byte order on addr_o can be checked phase by phase.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_EXEC  = 2'b01,
    CYC_DMA   = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  localparam int unsigned OP_W  = 8;
  localparam int unsigned NIB_W = OP_W / 2;
  localparam logic [NIB_W-1:0] GRP_LONG = 4'hC;
  localparam logic [OP_W-1:0]  OP_IDLE  = 8'h00;
endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
  parameter int unsigned PHASES = 8,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST_P = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (phase_q == LAST_P) phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign last_o  = (phase_q == LAST_P);

  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != LAST_P) |=> (phase_q == $past(phase_q) + 1'b1));
  p_phase_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_q == '0));
endmodule

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  output logic [NIB_W-1:0] group_o,
  output logic [NIB_W-1:0] reg_o,
  output logic             idle_o,
  output logic             long_o
);
  assign group_o = op_i[OP_W-1:NIB_W];
  assign reg_o   = op_i[NIB_W-1:0];
  assign idle_o  = (op_i == OP_IDLE);
  assign long_o  = (group_o == GRP_LONG);
endmodule

// File: rtl/mcs_addr_mux.sv
module mcs_addr_mux #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HI_PHASES = 2,
  parameter int unsigned PW        = 3,
  localparam int unsigned BUS_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BUS_W-1:0]  addr_o,
  output logic              ale_o
);
  localparam logic [PW-1:0] HI_P = PW'(HI_PHASES);

  assign ale_o  = (phase_i < HI_P);
  assign addr_o = ale_o ? addr_i[ADDR_W-1:BUS_W] : addr_i[BUS_W-1:0];

  p_ale_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (phase_i == HI_P));
  p_ale_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> (phase_i == '0));
endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import mcs_pkg::*;
#(
  parameter int unsigned PHASES    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HI_PHASES = 2,
  localparam int unsigned PW    = $clog2(PHASES),
  localparam int unsigned BUS_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              dma_req_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BUS_W-1:0]  addr_o,
  output logic              ale_o,
  output logic [1:0]        sc_o,
  output logic [PW-1:0]     phase_o,
  output logic              cycle_end_o,
  output logic [3:0]        op_group_o,
  output logic [3:0]        op_reg_o,
  output logic              idle_o
);
  logic [PW-1:0]   phase;
  logic            last;
  cyc_e            state_q, state_d;
  logic [OP_W-1:0] ir_q;
  logic            first_q;
  logic            dec_idle, dec_long, boundary;

  mcs_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase), .last_o(last));

  mcs_decode u_dec (
    .op_i(ir_q), .group_o(op_group_o), .reg_o(op_reg_o),
    .idle_o(dec_idle), .long_o(dec_long));

  mcs_addr_mux #(.ADDR_W(ADDR_W), .HI_PHASES(HI_PHASES), .PW(PW)) u_amux (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .addr_i(addr_i),
    .addr_o(addr_o), .ale_o(ale_o));

  always_comb begin
    state_d  = state_q;
    boundary = 1'b0;
    unique case (state_q)
      CYC_FETCH: state_d = CYC_EXEC;
      CYC_EXEC: begin
        if (dec_long && first_q && !dec_idle) state_d = CYC_EXEC;
        else                                  boundary = 1'b1;
      end
      CYC_DMA:   boundary = 1'b1;
      CYC_INT:   state_d = dma_req_i ? CYC_DMA : CYC_FETCH;
      default:   state_d = CYC_FETCH;
    endcase
    if (boundary) begin
      if (dma_req_i)                            state_d = CYC_DMA;
      else if (irq_i)                           state_d = CYC_INT;
      else if (state_q == CYC_EXEC && dec_idle) state_d = CYC_EXEC;
      else                                      state_d = CYC_FETCH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CYC_FETCH;
      ir_q    <= '0;
      first_q <= 1'b0;
    end else if (last) begin
      state_q <= state_d;
      first_q <= (state_q == CYC_FETCH);
      if (state_q == CYC_FETCH) ir_q <= opcode_i;
    end
  end

  assign sc_o        = state_q;
  assign phase_o     = phase;
  assign cycle_end_o = last;
  assign idle_o      = (state_q == CYC_EXEC) && dec_idle;

  p_frame_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != '0) |-> $stable(sc_o));
  p_fetch_exec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && sc_o == CYC_FETCH) |=> (sc_o == CYC_EXEC));
  p_long_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && sc_o == CYC_EXEC && first_q && op_group_o == GRP_LONG) |=> (sc_o == CYC_EXEC));
  p_ir_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(last && $past(sc_o) == CYC_FETCH) && !$past(last) |-> $stable(ir_q));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && idle_o && !dma_req_i && !irq_i) |=> idle_o);
  p_dma_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && sc_o == CYC_DMA && dma_req_i) |=> (sc_o == CYC_DMA));
  p_int_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && sc_o == CYC_INT) |=> (sc_o != CYC_INT));
endmodule

// File: tb/mcycle_seq_bench.sv
`timescale 1ns/1ps
module mcycle_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0;
  logic        dma_req_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [15:0] addr_i = 16'hA53C;
  logic [7:0]  addr_o;
  logic        ale_o;
  logic [1:0]  sc_o;
  logic [2:0]  phase_o;
  logic        cycle_end_o;
  logic [3:0]  op_group_o, op_reg_o;
  logic        idle_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] sc;
    logic [3:0] grp;
    logic [3:0] rg;
    logic       idle;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  // bench model state
  logic [1:0] m_state = 2'b00;
  logic [7:0] m_ir    = 8'h00;
  logic       m_first = 1'b0;

  always #2 clk_i = ~clk_i;

  mcycle_seq u_mcycle_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .dma_req_i(dma_req_i),
    .opcode_i(opcode_i), .addr_i(addr_i), .addr_o(addr_o), .ale_o(ale_o),
    .sc_o(sc_o), .phase_o(phase_o), .cycle_end_o(cycle_end_o),
    .op_group_o(op_group_o), .op_reg_o(op_reg_o), .idle_o(idle_o));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one frame: drive inputs at phase-0 falling edge, push expectation, step model
  task automatic do_cycle(input logic [7:0] op, input bit dma, input bit irq, input string req);
    logic [1:0] nxt;
    bit         bnd;
    while (phase_o != 3'd0) @(negedge clk_i);
    opcode_i  = op;
    dma_req_i = dma;
    irq_i     = irq;
    sb_q.push_back('{m_state, m_ir[7:4], m_ir[3:0], (m_state == 2'b01) && (m_ir == 8'h00), req});
    bnd = 1'b0;
    nxt = m_state;
    case (m_state)
      2'b00: nxt = 2'b01;
      2'b01: if (m_ir[7:4] == 4'hC && m_first) nxt = 2'b01; else bnd = 1'b1;
      2'b10: bnd = 1'b1;
      default: nxt = dma ? 2'b10 : 2'b00;
    endcase
    if (bnd) nxt = dma ? 2'b10 : irq ? 2'b11 : (m_state == 2'b01 && m_ir == 8'h00) ? 2'b01 : 2'b00;
    m_first = (m_state == 2'b00);
    if (m_state == 2'b00) m_ir = op;
    m_state = nxt;
    @(negedge clk_i);
  endtask

  // scoreboard monitor: compare once per frame at phase 3
  initial begin
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      if (phase_o == 3'd3 && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(sc_o == e.sc, e.req, "cycle code (R10)", 16'(sc_o), 16'(e.sc));
        check(op_group_o == e.grp && op_reg_o == e.rg, e.req, "group/reg R5",
              {8'h0, op_group_o, op_reg_o}, {8'h0, e.grp, e.rg});
        check(idle_o == e.idle, e.req, "idle R6", 16'(idle_o), 16'(e.idle));
      end
    end
  end

  // phase and address byte monitor (R1, R9)
  initial begin
    logic [2:0] exp_ph;
    exp_ph = 3'd1;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      check(phase_o == exp_ph, "R1", "phase", 16'(phase_o), 16'(exp_ph));
      check(cycle_end_o == (exp_ph == 3'd7), "R1", "cycle end", 16'(cycle_end_o), 16'(exp_ph == 3'd7));
      check(ale_o == (exp_ph < 3'd2), "R9", "ale", 16'(ale_o), 16'(exp_ph < 3'd2));
      check(addr_o == ((exp_ph < 3'd2) ? addr_i[15:8] : addr_i[7:0]), "R9", "addr byte",
            16'(addr_o), 16'((exp_ph < 3'd2) ? addr_i[15:8] : addr_i[7:0]));
      exp_ph = exp_ph + 3'd1;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(sc_o == 2'b00 && phase_o == 3'd0, "R2", "reset code/phase", {11'h0, sc_o, phase_o}, 16'h0);
    check(ale_o == 1'b1 && addr_o == 8'hA5, "R2", "reset addr", {7'h0, ale_o, addr_o}, 16'h01A5);
    check(idle_o == 1'b0 && op_group_o == 4'h0 && op_reg_o == 4'h0, "R2", "reset decode",
          {7'h0, idle_o, op_group_o, op_reg_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // ordinary opcodes
    do_cycle(8'h15, 0, 0, "R3"); do_cycle(8'h00, 0, 0, "R3");
    do_cycle(8'h3A, 0, 0, "R3"); do_cycle(8'h00, 0, 0, "R3");
    // long group
    do_cycle(8'hC4, 0, 0, "R4"); do_cycle(8'h00, 0, 0, "R4"); do_cycle(8'h00, 0, 0, "R4");
    do_cycle(8'hCF, 0, 0, "R4"); do_cycle(8'h00, 0, 0, "R4"); do_cycle(8'h00, 0, 0, "R4");
    // idle, left by interrupt, interrupt held during its own frame
    do_cycle(8'h00, 0, 0, "R6"); do_cycle(8'h00, 0, 0, "R6"); do_cycle(8'h00, 0, 0, "R6");
    do_cycle(8'h00, 0, 1, "R6"); do_cycle(8'h00, 0, 1, "R8");
    // idle, left by DMA
    do_cycle(8'h00, 0, 0, "R6"); do_cycle(8'h00, 1, 0, "R6"); do_cycle(8'h00, 0, 0, "R7");
    // priority and DMA hold
    do_cycle(8'h27, 0, 0, "R7"); do_cycle(8'h00, 1, 1, "R7");
    do_cycle(8'h00, 1, 1, "R7"); do_cycle(8'h00, 0, 1, "R7");
    do_cycle(8'h00, 0, 0, "R8");
    do_cycle(8'hC1, 0, 0, "R4"); do_cycle(8'h00, 0, 0, "R4"); do_cycle(8'h00, 1, 0, "R7");
    do_cycle(8'h00, 0, 0, "R7");
    // interrupt frame with DMA pending
    do_cycle(8'h5E, 0, 0, "R5"); do_cycle(8'h00, 0, 1, "R7"); do_cycle(8'h00, 1, 1, "R8");
    do_cycle(8'h00, 0, 0, "R7");
    do_cycle(8'h84, 0, 0, "R5"); do_cycle(8'h00, 0, 0, "R5");
    do_cycle(8'hF0, 0, 0, "R5"); do_cycle(8'h00, 0, 0, "R5");
    repeat (10) @(negedge clk_i);
    check(sb_q.size() == 0, "R1", "scoreboard drained", 16'(sb_q.size()), 16'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule